// File: doc/BRIEF.md
# Unsigned Long Division Unit

This block is the multi-cycle unsigned divide engine of a 32-bit processor datapath. A request carries a 32-bit divisor, a dividend and two destination register indices. The dividend is either the single 32-bit word `dividend_lo` or, in wide mode, the 64-bit value `{dividend_hi, dividend_lo}`. The unit returns a 32-bit quotient and a 32-bit remainder. It also returns write enables and indices for the quotient destination and the remainder destination, and a set of condition flags.

Operands are captured on the cycle a start request is accepted. A restoring shift-subtract loop then retires one quotient bit per cycle. A zero divisor ends the operation at once with a divide-by-zero indication. A wide dividend whose upper word is not below the divisor also ends at once, with overflow raised. In both of those cases no register write is requested. When the two destination indices match, only the quotient is written.

Top module: `udiv_unit`

## Requirements
- R1: After reset, `busy`, `done`, `q_we` and `r_we` are low, and the flags `flag_n`, `flag_z`, `flag_v`, `flag_c` and `div_zero` are low.
- R2: With `wide` = 0, the dividend is `dividend_lo` alone and `dividend_hi` has no effect. On completion `quotient` and `remainder` hold the unsigned quotient and remainder, and `q_we` is high with `q_wr_idx` equal to the accepted `q_idx`.
- R3: With `wide` = 1 and `dividend_hi` < `divisor`, the dividend is `{dividend_hi, dividend_lo}` and the 32-bit results are exact.
- R4: On normal completion, `r_we` is high with `r_wr_idx` equal to the accepted `r_idx`, unless `r_idx` equals `q_idx`. In that case `r_we` stays low while `q_we` is still high.
- R5: With `wide` = 1, a nonzero divisor and `dividend_hi` >= `divisor`, `done` rises in the cycle right after the accepting edge and `busy` never rises. In that cycle `flag_v` = 1, `q_we` = `r_we` = 0, and `quotient`, `remainder`, `flag_n` and `flag_z` are 0.
- R6: A zero divisor takes precedence over overflow. `done` rises in the cycle right after the accepting edge with `div_zero` = 1, `flag_v` = 0 and no write enables, and `busy` never rises.
- R7: For a divide that runs, `busy` is high from the accepting edge through the 32nd following rising edge. `done` is high for exactly one cycle, the one after that edge, and is never high together with `busy`.
- R8: Flags go with the result: `flag_n` is `quotient[31]`, `flag_z` is 1 when the quotient is zero, `flag_v` is the overflow indication, and `flag_c` is always 0.
- R9: A start request is accepted only while `busy` is low. Starts raised while busy, and operand changes after acceptance, have no effect on the running result or its timing.
- R10: `quotient`, `remainder` and the flags hold their values after `done` until the next accepted start. `q_we` and `r_we` are high only in the `done` cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request a divide; accepted when not busy |
| wide | input | 1 | 1: 64-bit dividend from hi:lo; 0: 32-bit dividend from lo |
| dividend_lo | input | 32 | Low dividend word (quotient destination's value) |
| dividend_hi | input | 32 | High dividend word (remainder destination's value) |
| divisor | input | 32 | Divisor operand |
| q_idx | input | 4 | Quotient destination register index |
| r_idx | input | 4 | Remainder destination register index |
| busy | output | 1 | Iteration in progress |
| done | output | 1 | One-cycle completion pulse |
| quotient | output | 32 | Quotient result |
| remainder | output | 32 | Remainder result |
| q_we | output | 1 | Quotient write enable (done cycle only) |
| q_wr_idx | output | 4 | Quotient write index |
| r_we | output | 1 | Remainder write enable (done cycle only) |
| r_wr_idx | output | 4 | Remainder write index |
| div_zero | output | 1 | Divide-by-zero indication |
| flag_n | output | 1 | Negative flag: quotient MSB |
| flag_z | output | 1 | Zero flag: quotient is zero |
| flag_v | output | 1 | Overflow flag |
| flag_c | output | 1 | Carry flag, always 0 |

## Verification
The bound checker watches several rules on every cycle. `done` lasts one cycle and never overlaps `busy`. Zero-divisor and overflow requests finish in the next cycle with no write enable. The remainder write follows the index comparison. A counter in the checker confirms that a completed divide took exactly 32 busy cycles, and that its remainder is below the divisor captured at acceptance. Only the bench scenarios can show that the quotient and remainder values are arithmetically right in both dividend modes. The bench scenarios also show that starts during busy and later operand changes leave the result alone, and that results and flags are held after `done`.

// File: rtl/udiv_unit.sv
module udiv_unit #(
  parameter int W    = 32,
  parameter int IDXW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            wide,
  input  logic [W-1:0]    dividend_lo,
  input  logic [W-1:0]    dividend_hi,
  input  logic [W-1:0]    divisor,
  input  logic [IDXW-1:0] q_idx,
  input  logic [IDXW-1:0] r_idx,
  output logic            busy,
  output logic            done,
  output logic [W-1:0]    quotient,
  output logic [W-1:0]    remainder,
  output logic            q_we,
  output logic [IDXW-1:0] q_wr_idx,
  output logic            r_we,
  output logic [IDXW-1:0] r_wr_idx,
  output logic            div_zero,
  output logic            flag_n,
  output logic            flag_z,
  output logic            flag_v,
  output logic            flag_c
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  acc, quo, dsr;
  logic [CW-1:0] cnt;

  wire          accept  = start && !busy;
  wire          zero_dv = (divisor == '0);
  wire          ovf_dv  = wide && (dividend_hi >= divisor);
  wire [W:0]    trial   = {acc, quo[W-1]} - {1'b0, dsr};
  wire          take    = !trial[W];
  wire [W-1:0]  acc_nx  = take ? trial[W-1:0] : {acc[W-2:0], quo[W-1]};
  wire [W-1:0]  quo_nx  = {quo[W-2:0], take};
  wire          last    = (cnt == CW'(W - 1));

  assign flag_c = 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      done      <= 1'b0;
      q_we      <= 1'b0;
      r_we      <= 1'b0;
      acc       <= '0;
      quo       <= '0;
      dsr       <= '0;
      cnt       <= '0;
      quotient  <= '0;
      remainder <= '0;
      q_wr_idx  <= '0;
      r_wr_idx  <= '0;
      div_zero  <= 1'b0;
      flag_n    <= 1'b0;
      flag_z    <= 1'b0;
      flag_v    <= 1'b0;
    end else begin
      done <= 1'b0;
      q_we <= 1'b0;
      r_we <= 1'b0;
      if (accept) begin
        q_wr_idx <= q_idx;
        r_wr_idx <= r_idx;
        if (zero_dv || ovf_dv) begin
          done      <= 1'b1;
          div_zero  <= zero_dv;
          flag_v    <= !zero_dv;
          flag_n    <= 1'b0;
          flag_z    <= 1'b0;
          quotient  <= '0;
          remainder <= '0;
        end else begin
          busy <= 1'b1;
          cnt  <= '0;
          acc  <= wide ? dividend_hi : '0;
          quo  <= dividend_lo;
          dsr  <= divisor;
        end
      end else if (busy) begin
        acc <= acc_nx;
        quo <= quo_nx;
        cnt <= cnt + 1'b1;
        if (last) begin
          busy      <= 1'b0;
          done      <= 1'b1;
          q_we      <= 1'b1;
          r_we      <= (q_wr_idx != r_wr_idx);
          quotient  <= quo_nx;
          remainder <= acc_nx;
          div_zero  <= 1'b0;
          flag_v    <= 1'b0;
          flag_n    <= quo_nx[W-1];
          flag_z    <= (quo_nx == '0);
        end
      end
    end
  end
endmodule

module udiv_unit_chk #(
  parameter int W    = 32,
  parameter int IDXW = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            wide,
  input logic [W-1:0]    dividend_hi,
  input logic [W-1:0]    divisor,
  input logic            busy,
  input logic            done,
  input logic [W-1:0]    remainder,
  input logic            q_we,
  input logic            r_we,
  input logic [IDXW-1:0] q_wr_idx,
  input logic [IDXW-1:0] r_wr_idx,
  input logic            div_zero,
  input logic            flag_v
);
  localparam int CW = $clog2(W + 2);
  logic [CW-1:0] run_cnt;
  logic [W-1:0]  dv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt <= '0;
      dv_q    <= '0;
    end else if (start && !busy) begin
      run_cnt <= '0;
      dv_q    <= divisor;
    end else if (busy) begin
      run_cnt <= run_cnt + 1'b1;
    end
  end

  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r7_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));
  a_r7_latency: assert property (@(posedge clk) disable iff (!rst_n)
    q_we |-> run_cnt == CW'(W));
  a_r6_dz_immediate: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && divisor == '0) |=> (done && div_zero && !flag_v && !busy && !q_we && !r_we));
  a_r5_ovf_immediate: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && divisor != '0 && wide && dividend_hi >= divisor) |=> (done && flag_v && !busy && !q_we && !r_we));
  a_r4_r_we_rule: assert property (@(posedge clk) disable iff (!rst_n)
    r_we |-> (q_we && q_wr_idx != r_wr_idx));
  a_r10_we_only_done: assert property (@(posedge clk) disable iff (!rst_n)
    q_we |-> done);
  a_r2_rem_below_divisor: assert property (@(posedge clk) disable iff (!rst_n)
    q_we |-> remainder < dv_q);
endmodule

bind udiv_unit udiv_unit_chk #(.W(W), .IDXW(IDXW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .wide(wide),
  .dividend_hi(dividend_hi), .divisor(divisor), .busy(busy), .done(done),
  .remainder(remainder), .q_we(q_we), .r_we(r_we), .q_wr_idx(q_wr_idx),
  .r_wr_idx(r_wr_idx), .div_zero(div_zero), .flag_v(flag_v)
);

// File: tb/udiv_unit_tb.sv
module udiv_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, wide = 1'b0;
  logic [31:0] dividend_lo = '0, dividend_hi = '0, divisor = '0;
  logic [3:0]  q_idx = '0, r_idx = '0;
  logic        busy, done, q_we, r_we, div_zero, flag_n, flag_z, flag_v, flag_c;
  logic [31:0] quotient, remainder;
  logic [3:0]  q_wr_idx, r_wr_idx;

  int checks = 0, errors = 0, cyc = 0;

  always #4 clk = ~clk;

  udiv_unit u_dut (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles expected < 100000", cyc);
      finish_run();
    end
  end

  // issue one request and wait for done; returns cycles from accept to done
  task automatic issue(input bit w, input logic [31:0] hi, lo, dv,
                       input logic [3:0] qi, ri, output int lat, output bit saw_busy);
    @(negedge clk);
    wide = w; dividend_hi = hi; dividend_lo = lo; divisor = dv;
    q_idx = qi; r_idx = ri; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1; saw_busy = busy;
    while (!done && lat < 200) begin
      @(negedge clk);
      lat++;
      if (busy) saw_busy = 1'b1;
    end
  endtask

  task automatic check_done(input string req, input bit w, input logic [31:0] hi, lo, dv,
                            input logic [3:0] qi, ri, input int lat, input bit saw_busy);
    logic [63:0] dvd;
    logic [31:0] eq, er;
    bit ez, eo;
    dvd = w ? {hi, lo} : {32'd0, lo};
    ez = (dv == 0);
    eo = !ez && w && (hi >= dv);
    eq = (ez || eo) ? 32'd0 : 32'(dvd / {32'd0, dv});
    er = (ez || eo) ? 32'd0 : 32'(dvd % {32'd0, dv});
    chk(done, req, "done", 64'(done), 1);
    chk(lat == ((ez || eo) ? 1 : 33), "R7", "latency", 64'(lat), (ez || eo) ? 1 : 33);
    chk(saw_busy == !(ez || eo), "R7", "busy seen", 64'(saw_busy), 64'(!(ez || eo)));
    chk(quotient == eq, req, "quotient", quotient, eq);
    chk(remainder == er, req, "remainder", remainder, er);
    chk(div_zero == ez, "R6", "div_zero", 64'(div_zero), 64'(ez));
    chk(flag_v == eo, "R5", "flag_v", 64'(flag_v), 64'(eo));
    chk(flag_n == eq[31], "R8", "flag_n", 64'(flag_n), 64'(eq[31]));
    chk(flag_z == (!(ez || eo) && eq == 0), "R8", "flag_z", 64'(flag_z), 64'(!(ez || eo) && eq == 0));
    chk(flag_c == 1'b0, "R8", "flag_c", 64'(flag_c), 0);
    chk(q_we == !(ez || eo), "R2", "q_we", 64'(q_we), 64'(!(ez || eo)));
    chk(r_we == (!(ez || eo) && qi != ri), "R4", "r_we", 64'(r_we), 64'(!(ez || eo) && qi != ri));
    if (!(ez || eo)) begin
      chk(q_wr_idx == qi, "R2", "q_wr_idx", 64'(q_wr_idx), 64'(qi));
      if (qi != ri) chk(r_wr_idx == ri, "R4", "r_wr_idx", 64'(r_wr_idx), 64'(ri));
    end
  endtask

  task automatic run_case(input string req, input bit w, input logic [31:0] hi, lo, dv,
                          input logic [3:0] qi, ri);
    int lat;
    bit sb;
    issue(w, hi, lo, dv, qi, ri, lat, sb);
    check_done(req, w, hi, lo, dv, qi, ri, lat, sb);
  endtask

  task automatic t_reset();
    chk(!busy && !done && !q_we && !r_we, "R1", "busy/done/we", {busy, done, q_we, r_we}, 0);
    chk(!flag_n && !flag_z && !flag_v && !flag_c && !div_zero, "R1", "flags",
        {flag_n, flag_z, flag_v, flag_c, div_zero}, 0);
  endtask

  task automatic t_narrow();
    run_case("R2", 1'b0, 32'hFFFF_FFFF, 32'd1000, 32'd7, 4'd2, 4'd3);
    run_case("R2", 1'b0, 32'h1234_5678, 32'hFFFF_FFFF, 32'd1, 4'd0, 4'd1);
    run_case("R2", 1'b0, 32'd0, 32'd5, 32'd9, 4'd4, 4'd5);
    run_case("R2", 1'b0, 32'd0, 32'h8000_0000, 32'hFFFF_FFFF, 4'd6, 4'd7);
  endtask

  task automatic t_wide();
    run_case("R3", 1'b1, 32'd6, 32'hDEAD_BEEF, 32'd7, 4'd1, 4'd2);
    run_case("R3", 1'b1, 32'hFFFF_FFFE, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'd3, 4'd9);
    run_case("R3", 1'b1, 32'h0000_0001, 32'h0000_0000, 32'h0000_0002, 4'd8, 4'd10);
  endtask

  task automatic t_same_idx();
    run_case("R4", 1'b0, 32'd0, 32'd100, 32'd9, 4'd5, 4'd5);
    run_case("R4", 1'b1, 32'd3, 32'd100, 32'd9, 4'd11, 4'd11);
  endtask

  task automatic t_overflow();
    run_case("R5", 1'b1, 32'd7, 32'd0, 32'd7, 4'd1, 4'd2);
    run_case("R5", 1'b1, 32'hFFFF_FFFF, 32'd0, 32'd1, 4'd1, 4'd2);
  endtask

  task automatic t_divzero();
    run_case("R6", 1'b0, 32'd0, 32'd55, 32'd0, 4'd1, 4'd2);
    run_case("R6", 1'b1, 32'd9, 32'd55, 32'd0, 4'd1, 4'd2);
  endtask

  task automatic t_ignore_start();
    int lat;
    bit sb;
    @(negedge clk);
    wide = 1'b0; dividend_hi = 0; dividend_lo = 32'd12345; divisor = 32'd10;
    q_idx = 4'd1; r_idx = 4'd2; start = 1'b1;
    @(negedge clk);
    start = 1'b0; lat = 1; sb = busy;
    dividend_lo = 32'd999; divisor = 32'd0; wide = 1'b1; dividend_hi = 32'd77;
    q_idx = 4'd3; r_idx = 4'd3;
    repeat (3) begin @(negedge clk); lat++; end
    start = 1'b1;
    repeat (4) begin @(negedge clk); lat++; end
    start = 1'b0;
    while (!done && lat < 200) begin @(negedge clk); lat++; end
    check_done("R9", 1'b0, 32'd0, 32'd12345, 32'd10, 4'd1, 4'd2, lat, sb);
  endtask

  task automatic t_hold();
    logic [31:0] q0, r0;
    run_case("R10", 1'b0, 32'd0, 32'hF000_0000, 32'd3, 4'd1, 4'd2);
    q0 = quotient; r0 = remainder;
    dividend_lo = 32'd1; divisor = 32'd1;
    repeat (3) @(negedge clk);
    chk(!done && !q_we && !r_we, "R10", "pulses after done", {done, q_we, r_we}, 0);
    chk(quotient == q0 && remainder == r0, "R10", "held result", {quotient, remainder}, {q0, r0});
    chk(flag_n == q0[31], "R10", "held flag_n", 64'(flag_n), 64'(q0[31]));
  endtask

  task automatic t_mixed();
    for (int i = 0; i < 12; i++) begin
      logic [31:0] dv, hi, lo;
      dv = $urandom() | 32'd1;
      hi = $urandom() % dv;
      lo = $urandom();
      run_case(i[0] ? "R3" : "R2", i[0], hi, lo, dv, 4'(i), 4'(i + 1));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_narrow();
    t_wide();
    t_same_idx();
    t_overflow();
    t_divzero();
    t_ignore_start();
    t_hold();
    t_mixed();
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule